// File: doc/BRIEF.md
# Two-Level Next Occupied Slot Finder

This block keeps one occupancy bit for every slot of a timing wheel and answers the question "which is the first occupied slot at or after position S, going round the wheel?" A scheduler that walks a timing wheel uses it to jump its pointer straight to the next slot that has work. It does not have to step over empty slots one at a time. The linked lists that hang off each slot live elsewhere. This block only tracks whether each list is empty.

The occupancy bits are grouped into words of `WORD_W` bits, and there are `NUM_WORDS` such words. A second, summary vector holds one bit per word, and that bit is set when its word has any bit set. A lookup reads the summary and the word that holds the start slot. From these it picks the one word that must hold the answer, and then reads that word. So every lookup costs the same two-level read no matter how far away the next occupied slot is. A new lookup can be issued every cycle, and its result is registered one cycle later. Updates set or clear a single slot bit and keep the summary consistent in the same clock edge.

With the default 32 words of 32 bits the wheel has 1024 slots. With 128-bit words and 128 words the same structure covers 16,384 slots.

Top module: `slot_finder`

## Requirements
- R1: `res_valid` is asserted in exactly the cycle after each cycle in which `srch_valid` is high, and is low otherwise. A lookup may be issued every cycle.
- R2: When a clear removes the last set bit of an occupancy word, that word stops being considered in the same update. A later lookup starting inside or before that word skips it and returns the next occupied slot beyond it.
- R3: When an occupied slot exists at index `srch_start` or above, the result has `res_found` = 1 and `res_slot` = the lowest such occupied index.
- R4: When no slot at or above `srch_start` is occupied but some slot is, the search wraps. It returns `res_found` = 1 and the lowest occupied index of the whole wheel, which may sit in the same word as the start, below it.
- R5: When no slot is occupied, the result has `res_found` = 0 and `res_slot` = 0.
- R6: An update with `upd_valid` = 1 sets slot `upd_slot` when `upd_set` = 1 and clears it when `upd_set` = 0. It is seen by lookups issued in later cycles. A lookup issued in the same cycle as an update sees the occupancy from before that update.
- R7: Setting a slot that is already set, or clearing a slot that is already clear, has no effect on any lookup result.
- R8: The start slot itself counts. If `srch_start` is occupied, the result is `srch_start`, including the last slot of the wheel.
- R9: After reset every slot is empty and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Apply a slot update this cycle |
| upd_set | input | 1 | 1 marks the slot occupied, 0 marks it empty |
| upd_slot | input | SLOT_W (10) | Slot index to update |
| srch_valid | input | 1 | Start a lookup this cycle |
| srch_start | input | SLOT_W (10) | First slot the lookup considers |
| res_valid | output | 1 | Lookup result valid, one cycle after the request |
| res_found | output | 1 | At least one slot was occupied |
| res_slot | output | SLOT_W (10) | Next occupied slot, 0 when none found |

## Verification
The assertions assume that `upd_slot` and `srch_start` are always below the number of slots. Because the slot count is a power of two, any value the ports can carry already satisfies this. They also assume that at most one update arrives per cycle, which the single update port enforces. The result checks compare against the occupancy held one cycle earlier, so they rely on the lookup and the update being ordered as R6 states. The bench applies every change on the falling edge, with one update and at most one lookup per cycle. This includes the deliberate case of an update and a lookup in the same cycle.

// File: rtl/slot_finder_pkg.sv
package slot_finder_pkg;
  typedef enum logic {
    OP_CLEAR = 1'b0,
    OP_SET   = 1'b1
  } slot_op_e;
endpackage

// File: rtl/slot_prienc.sv
// Lowest-set-bit encoder: idx is the position of the least significant 1.
module slot_prienc #(
  parameter int W  = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/slot_occ_store.sv
// Occupancy words plus per-word summary, both registered together.
module slot_occ_store #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 32,
  localparam int NUM_SLOTS = WORD_W * NUM_WORDS,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int OFF_W     = $clog2(WORD_W),
  localparam int WIDX_W    = SLOT_W - OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  slot_finder_pkg::slot_op_e wr_op,
  input  logic [SLOT_W-1:0]    wr_slot,
  output logic [NUM_SLOTS-1:0] occ_flat,
  output logic [NUM_WORDS-1:0] summary
);
  logic [WIDX_W-1:0] wr_word;
  logic [OFF_W-1:0]  wr_off;

  assign wr_word = wr_slot[SLOT_W-1:OFF_W];
  assign wr_off  = wr_slot[OFF_W-1:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_nxt;
    logic              sum_q;
    logic              word_hit;

    assign word_hit = wr_en && (wr_word == WIDX_W'(w));

    always_comb begin
      word_nxt = word_q;
      if (word_hit) word_nxt[wr_off] = (wr_op == slot_finder_pkg::OP_SET);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
        sum_q  <= 1'b0;
      end else begin
        word_q <= word_nxt;
        sum_q  <= |word_nxt;
      end
    end

    assign occ_flat[w*WORD_W +: WORD_W] = word_q;
    assign summary[w]                   = sum_q;
  end
endmodule

// File: rtl/slot_search.sv
// Combinational two-level lookup: summary picks the word, the word picks the bit.
module slot_search #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 32,
  localparam int NUM_SLOTS = WORD_W * NUM_WORDS,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int OFF_W     = $clog2(WORD_W),
  localparam int WIDX_W    = SLOT_W - OFF_W
) (
  input  logic [NUM_SLOTS-1:0] occ_flat,
  input  logic [NUM_WORDS-1:0] summary,
  input  logic [SLOT_W-1:0]    start,
  output logic                 found,
  output logic [SLOT_W-1:0]    slot,
  output logic                 hit_direct,
  output logic                 hit_above,
  output logic                 hit_wrap
);
  // Bits at or above offset within one occupancy word.
  function automatic logic [WORD_W-1:0] keep_from(input logic [OFF_W-1:0] off);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = (i >= int'(off));
    return m;
  endfunction

  // Summary bits strictly above a word index.
  function automatic logic [NUM_WORDS-1:0] keep_above(input logic [WIDX_W-1:0] w);
    logic [NUM_WORDS-1:0] m;
    for (int i = 0; i < NUM_WORDS; i++) m[i] = (i > int'(w));
    return m;
  endfunction

  logic [WIDX_W-1:0]    start_word;
  logic [OFF_W-1:0]     start_off;
  logic [WORD_W-1:0]    start_bits;
  logic [WORD_W-1:0]    cur_masked;
  logic [NUM_WORDS-1:0] sum_above;
  logic [WIDX_W-1:0]    above_idx;
  logic [WIDX_W-1:0]    first_idx;
  logic                 any_cur;
  logic                 any_above;
  logic                 any_word;
  logic [WIDX_W-1:0]    sel_word;
  logic [WORD_W-1:0]    sel_bits;
  logic [WORD_W-1:0]    pick_bits;
  logic [OFF_W-1:0]     pick_off;
  logic                 pick_any;

  assign start_word = start[SLOT_W-1:OFF_W];
  assign start_off  = start[OFF_W-1:0];
  assign start_bits = occ_flat[{start_word, {OFF_W{1'b0}}} +: WORD_W];
  assign cur_masked = start_bits & keep_from(start_off);
  assign sum_above  = summary & keep_above(start_word);

  slot_prienc #(.W(WORD_W)) u_cur_enc (
    .vec(cur_masked), .idx(), .any(any_cur)
  );
  slot_prienc #(.W(NUM_WORDS)) u_above_enc (
    .vec(sum_above), .idx(above_idx), .any(any_above)
  );
  slot_prienc #(.W(NUM_WORDS)) u_first_enc (
    .vec(summary), .idx(first_idx), .any(any_word)
  );

  assign hit_direct = any_cur;
  assign hit_above  = !any_cur && any_above;
  assign hit_wrap   = !any_cur && !any_above && any_word;

  always_comb begin
    if (hit_direct)     sel_word = start_word;
    else if (hit_above) sel_word = above_idx;
    else                sel_word = first_idx;
  end

  // Second read: the single word chosen by the summary level.
  assign sel_bits  = occ_flat[{sel_word, {OFF_W{1'b0}}} +: WORD_W];
  assign pick_bits = hit_direct ? cur_masked : sel_bits;

  slot_prienc #(.W(WORD_W)) u_bit_enc (
    .vec(pick_bits), .idx(pick_off), .any(pick_any)
  );

  assign found = hit_direct || hit_above || hit_wrap;
  assign slot  = (found && pick_any) ? {sel_word, pick_off} : '0;
endmodule

// File: rtl/slot_finder.sv
module slot_finder #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 32,
  localparam int NUM_SLOTS = WORD_W * NUM_WORDS,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic              upd_set,
  input  logic [SLOT_W-1:0] upd_slot,
  input  logic              srch_valid,
  input  logic [SLOT_W-1:0] srch_start,
  output logic              res_valid,
  output logic              res_found,
  output logic [SLOT_W-1:0] res_slot
);
  import slot_finder_pkg::*;

  logic [NUM_SLOTS-1:0] occ_flat;
  logic [NUM_WORDS-1:0] summary;
  logic                 look_found;
  logic [SLOT_W-1:0]    look_slot;
  logic                 hit_direct;
  logic                 hit_above;
  logic                 hit_wrap;
  slot_op_e             upd_op;

  assign upd_op = upd_set ? OP_SET : OP_CLEAR;

  slot_occ_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (upd_valid),
    .wr_op   (upd_op),
    .wr_slot (upd_slot),
    .occ_flat(occ_flat),
    .summary (summary)
  );

  slot_search #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_search (
    .occ_flat  (occ_flat),
    .summary   (summary),
    .start     (srch_start),
    .found     (look_found),
    .slot      (look_slot),
    .hit_direct(hit_direct),
    .hit_above (hit_above),
    .hit_wrap  (hit_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_found <= 1'b0;
      res_slot  <= '0;
    end else begin
      res_valid <= srch_valid;
      if (srch_valid) begin
        res_found <= look_found;
        res_slot  <= look_slot;
      end
    end
  end
endmodule

// File: rtl/slot_finder_chk.sv
module slot_finder_chk #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 32,
  localparam int NUM_SLOTS = WORD_W * NUM_WORDS,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 upd_valid,
  input logic                 upd_set,
  input logic [SLOT_W-1:0]    upd_slot,
  input logic                 srch_valid,
  input logic                 res_valid,
  input logic                 res_found,
  input logic [SLOT_W-1:0]    res_slot,
  input logic [NUM_SLOTS-1:0] occ_flat,
  input logic [NUM_WORDS-1:0] summary,
  input logic                 hit_direct,
  input logic                 hit_above,
  input logic                 hit_wrap
);
  logic [NUM_SLOTS-1:0] occ_prev;
  logic [NUM_WORDS-1:0] word_nonzero;

  always_ff @(posedge clk) begin
    if (!rst_n) occ_prev <= '0;
    else        occ_prev <= occ_flat;
  end

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++)
      word_nonzero[w] = |occ_flat[w*WORD_W +: WORD_W];
  end

  p_res_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    srch_valid |=> res_valid);
  p_res_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_valid |=> !res_valid);
  p_summary_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    summary == word_nonzero);
  p_found_occupied_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_found) |-> occ_prev[res_slot]);
  p_one_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_direct, hit_above, hit_wrap}));
  p_empty_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_found) |-> (occ_prev == '0 && res_slot == '0));
  p_set_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_set) |=> occ_flat[$past(upd_slot)]);
  p_clear_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_set) |=> !occ_flat[$past(upd_slot)]);
  p_redundant_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_set == occ_flat[upd_slot])) |=> $stable(occ_flat));
endmodule

bind slot_finder slot_finder_chk #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_valid (upd_valid),
  .upd_set   (upd_set),
  .upd_slot  (upd_slot),
  .srch_valid(srch_valid),
  .res_valid (res_valid),
  .res_found (res_found),
  .res_slot  (res_slot),
  .occ_flat  (occ_flat),
  .summary   (summary),
  .hit_direct(hit_direct),
  .hit_above (hit_above),
  .hit_wrap  (hit_wrap)
);

// File: tb/tb_slot_finder.sv
module tb_slot_finder;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 32;
  localparam int NUM_SLOTS = WORD_W * NUM_WORDS;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              upd_valid = 1'b0;
  logic              upd_set = 1'b0;
  logic [SLOT_W-1:0] upd_slot = '0;
  logic              srch_valid = 1'b0;
  logic [SLOT_W-1:0] srch_start = '0;
  logic              res_valid;
  logic              res_found;
  logic [SLOT_W-1:0] res_slot;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit model [NUM_SLOTS];

  always #10 clk = ~clk;

  slot_finder #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) dut (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_set(upd_set), .upd_slot(upd_slot),
    .srch_valid(srch_valid), .srch_start(srch_start),
    .res_valid(res_valid), .res_found(res_found), .res_slot(res_slot)
  );

  // Expected result: walk the wheel from the start, wrapping once.
  function automatic int expect_slot(input int start);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      int idx = (start + i) % NUM_SLOTS;
      if (model[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_result(input string req, input int exp);
    chk({req, " valid"}, int'(res_valid), 1);
    chk({req, " found"}, int'(res_found), (exp >= 0) ? 1 : 0);
    chk({req, " slot"}, int'(res_slot), (exp >= 0) ? exp : 0);
  endtask

  task automatic upd(input bit set, input int slot);
    upd_valid = 1'b1; upd_set = set; upd_slot = SLOT_W'(slot);
    @(posedge clk); @(negedge clk);
    upd_valid = 1'b0;
    model[slot] = set;
  endtask

  task automatic search(input string req, input int start);
    int exp = expect_slot(start);
    srch_valid = 1'b1; srch_start = SLOT_W'(start);
    @(posedge clk); @(negedge clk);
    srch_valid = 1'b0;
    chk_result(req, exp);
  endtask

  task automatic t_reset();
    chk("R9 res_valid after reset", int'(res_valid), 0);
    search("R9 empty after reset", 0);
    search("R5 empty wheel", 517);
  endtask

  task automatic t_start_and_wrap();
    upd(1'b1, 100);
    search("R8 start occupied", 100);
    search("R3 same word above start", 97);
    search("R4 wrap to lower bit same word", 101);
    upd(1'b1, 700);
    search("R3 found through summary", 101);
    search("R4 wrap across end", 1000);
  endtask

  task automatic t_clear_last();
    upd(1'b0, 100);
    search("R2 emptied word skipped", 96);
    search("R2 wrap past emptied word", 701);
  endtask

  task automatic t_redundant();
    upd(1'b1, 700);
    upd(1'b0, 100);
    search("R7 redundant updates no effect", 0);
    search("R7 redundant clear stays clear", 101);
    upd(1'b0, 700);
    search("R5 all cleared", 0);
  endtask

  task automatic t_same_cycle();
    int exp_old = expect_slot(0);
    upd_valid = 1'b1; upd_set = 1'b1; upd_slot = SLOT_W'(5);
    srch_valid = 1'b1; srch_start = '0;
    @(posedge clk); @(negedge clk);
    upd_valid = 1'b0; srch_valid = 1'b0;
    model[5] = 1'b1;
    chk_result("R6 lookup sees pre-update state", exp_old);
    search("R6 update visible next cycle", 0);
  endtask

  task automatic t_back_to_back();
    int ea, eb, ec;
    upd(1'b1, 1023);
    upd(1'b1, 0);
    ea = expect_slot(1); eb = expect_slot(6); ec = expect_slot(1023);
    srch_valid = 1'b1; srch_start = SLOT_W'(1);
    @(posedge clk); @(negedge clk);
    chk_result("R1 first of burst", ea);
    srch_start = SLOT_W'(6);
    @(posedge clk); @(negedge clk);
    chk_result("R1 second of burst", eb);
    srch_start = SLOT_W'(1023);
    @(posedge clk); @(negedge clk);
    srch_valid = 1'b0;
    chk_result("R8 last slot of wheel", ec);
    @(posedge clk); @(negedge clk);
    chk("R1 res_valid drops when idle", int'(res_valid), 0);
  endtask

  task automatic t_sweep();
    int seed = 12345;
    int prev_exp;
    for (int n = 0; n < 40; n++) begin
      seed = seed * 1103515245 + 12345;
      upd(1'b1, (seed >>> 8) & (NUM_SLOTS - 1));
    end
    for (int n = 0; n < 8; n++) begin
      seed = seed * 1103515245 + 12345;
      upd(1'b0, (seed >>> 8) & (NUM_SLOTS - 1));
    end
    srch_valid = 1'b1;
    for (int n = 0; n <= 64; n++) begin
      int st;
      seed = seed * 1103515245 + 12345;
      st = (seed >>> 8) & (NUM_SLOTS - 1);
      if (n > 0) chk_result("R3 R4 sweep", prev_exp);
      if (n == 64) break;
      srch_start = SLOT_W'(st);
      prev_exp = expect_slot(st);
      @(posedge clk); @(negedge clk);
    end
    srch_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NUM_SLOTS; i++) model[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_start_and_wrap();
    t_clear_last();
    t_redundant();
    t_same_cycle();
    t_back_to_back();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule